// File: doc/BRIEF.md
# Path-Addressed Boolean Netlist Evaluator

This block computes the value of a Boolean circuit held in an external gate table. It reads the table through a synchronous read port. The engine puts a gate index on `tblAddr`. One cycle later the table returns that gate's type, two predecessor indices and a literal bit. Evaluation is started by a one-cycle `start` pulse that carries the index of the output gate on `rootIdx`. When evaluation ends, a one-cycle `done` pulse appears together with the value on `result`. If the traversal would go deeper than the path store allows, `done` appears with `error` set instead.

The engine does not keep a stack of values or of gate indices. It holds a single bit string, which is the path from the output gate to the gate currently in focus, plus a depth count and one value bit. Bit 0 of a step selects the only predecessor of a NOT gate, or the lower-numbered predecessor of a two-input gate. Bit 1 selects the higher-numbered predecessor.

To revisit a parent, the engine drops the last path bit and walks again from the output gate, one table read per path bit. AND and OR gates are short-circuited. Their second input is visited only when the first input leaves the gate's value undecided.

Top module: `netlist_path_eval`

## Requirements
- R1: After reset, `done`, `result` and `error` are all 0.
- R2: Gate types are encoded as follows: 00 = input, whose value is the literal bit; 01 = NOT; 10 = AND; 11 = OR. The value reported on `result` is the Boolean value of the gate named by `rootIdx`. This includes the case where the root gate is itself an input.
- R3: Table read protocol. Once `tblAddr` changes, it holds for at least one more cycle. The record returned for an address is used in the cycle after that address was presented.
- R4: For an AND or OR gate, the predecessor with the smaller index is visited first, whichever table field holds it.
- R5: An AND gate whose first-visited predecessor is 0 takes the value 0. Its other predecessor is not visited, so an over-deep subtree there raises no error.
- R6: An OR gate whose first-visited predecessor is 1 takes the value 1. Its other predecessor is not visited.
- R7: A NOT gate takes the inverse of its predecessor. An AND or OR gate that is undecided after its first-visited predecessor takes the value of its other predecessor.
- R8: Depth limit. An input reached through exactly MAX_DEPTH path bits is evaluated normally. A descent below that depth ends the run with `done`=1, `error`=1 and `result`=0.
- R9: `done` is high for exactly one cycle per accepted start. `result` and `error` hold their values until the next accepted start.
- R10: A `start` pulse that arrives while an evaluation is running is ignored. The running evaluation completes with its own root's value and produces a single `done`.
- R11: In the cycle after a start is accepted, `tblAddr` equals the `rootIdx` value captured with that start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an evaluation |
| rootIdx | input | IDX_W | Index of the output gate, sampled together with start |
| tblAddr | output | IDX_W | Gate index presented to the table read port |
| tblType | input | 2 | Type of the gate read on the previous cycle |
| tblPredA | input | IDX_W | First predecessor field of that gate |
| tblPredB | input | IDX_W | Second predecessor field, unused by NOT and input gates |
| tblLit | input | 1 | Literal value of that gate when it is an input |
| done | output | 1 | One-cycle end-of-evaluation pulse |
| result | output | 1 | Value of the root gate; 0 when error is set |
| error | output | 1 | Set when the depth limit was exceeded |

## Verification
The assertions assume three things about the environment. The table answers every address with its record exactly one cycle later. The table contents stay unchanged while an evaluation runs. Every predecessor index is smaller than the index of the gate that names it, so the netlist has no cycles. The bench keeps to these assumptions: its table model registers its output on each edge, it rewrites entries only between runs, and it builds every circuit by appending gates whose predecessors already exist. For random netlists, roots are chosen only where the unfolded depth stays small, which keeps the number of re-walks bounded.

// File: rtl/npe_pkg.sv
package npe_pkg;

  typedef enum logic [1:0] {
    GT_INPUT = 2'b00,
    GT_NOT   = 2'b01,
    GT_AND   = 2'b10,
    GT_OR    = 2'b11
  } gateType_e;

  typedef enum logic [1:0] {
    VS_KEEP = 2'd0,
    VS_LIT  = 2'd1,
    VS_INV  = 2'd2
  } valSrc_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic    load;      // latch root, clear path and outputs
    logic    stepWalk;  // follow one stored path bit during a re-walk
    logic    descend;   // append a path bit and move to that child
    logic    dirOne;    // bit value appended on descend
    logic    ascend;    // drop last path bit, restart walk at root
    logic    finish;    // publish the value bit on result
    logic    fail;      // publish a depth error
    valSrc_e valSrc;    // next value bit source
  } strobes_t;

endpackage

// File: rtl/npe_dpath.sv
module npe_dpath
  import npe_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int MAX_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         ctl,
  input  logic [IDX_W-1:0] rootIdx,
  input  logic [1:0]       tblType,
  input  logic [IDX_W-1:0] tblPredA,
  input  logic [IDX_W-1:0] tblPredB,
  input  logic             tblLit,
  output logic [IDX_W-1:0] tblAddr,
  output logic             atTarget,
  output logic             depthZero,
  output logic             depthFull,
  output logic             childBit,
  output logic             valueBit,
  output logic             result,
  output logic             error
);

  localparam int DEP_W  = $clog2(MAX_DEPTH + 1);
  localparam int PATH_N = 1 << DEP_W;
  localparam logic [DEP_W-1:0] DEP_ONE = DEP_W'(1);
  localparam logic [DEP_W-1:0] DEP_MAX = DEP_W'(MAX_DEPTH);

  logic [IDX_W-1:0]  rootReg;
  logic [IDX_W-1:0]  curIdx;
  logic [DEP_W-1:0]  walkCnt;
  logic [DEP_W-1:0]  depth;
  logic [PATH_N-1:0] pathBits;
  logic              nextVal;

  // NOT follows its only predecessor; two-input gates order by index
  function automatic logic [IDX_W-1:0] pickChild(
    input logic [1:0] gType, input logic [IDX_W-1:0] a,
    input logic [IDX_W-1:0] b, input logic highSide);
    logic [IDX_W-1:0] lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    if (gType == GT_NOT) return a;
    return highSide ? hi : lo;
  endfunction

  always_comb begin
    unique case (ctl.valSrc)
      VS_LIT:  nextVal = tblLit;
      VS_INV:  nextVal = ~valueBit;
      default: nextVal = valueBit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rootReg  <= '0;
      curIdx   <= '0;
      walkCnt  <= '0;
      depth    <= '0;
      pathBits <= '0;
      childBit <= 1'b0;
      valueBit <= 1'b0;
      result   <= 1'b0;
      error    <= 1'b0;
    end else begin
      valueBit <= nextVal;
      if (ctl.load) begin
        rootReg  <= rootIdx;
        curIdx   <= rootIdx;
        walkCnt  <= '0;
        depth    <= '0;
        pathBits <= '0;
        result   <= 1'b0;
        error    <= 1'b0;
      end
      if (ctl.stepWalk) begin
        curIdx  <= pickChild(tblType, tblPredA, tblPredB, pathBits[walkCnt]);
        walkCnt <= walkCnt + DEP_ONE;
      end
      if (ctl.descend) begin
        pathBits[depth] <= ctl.dirOne;
        curIdx          <= pickChild(tblType, tblPredA, tblPredB, ctl.dirOne);
        depth           <= depth + DEP_ONE;
        walkCnt         <= depth + DEP_ONE;
      end
      if (ctl.ascend) begin
        childBit <= pathBits[depth - DEP_ONE];
        depth    <= depth - DEP_ONE;
        curIdx   <= rootReg;
        walkCnt  <= '0;
      end
      if (ctl.finish) begin
        result <= nextVal;
        error  <= 1'b0;
      end
      if (ctl.fail) begin
        result <= 1'b0;
        error  <= 1'b1;
      end
    end
  end

  assign tblAddr   = curIdx;
  assign atTarget  = (walkCnt == depth);
  assign depthZero = (depth == '0);
  assign depthFull = (depth == DEP_MAX);

endmodule

// File: rtl/npe_ctrl.sv
module npe_ctrl
  import npe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] tblType,
  input  logic       atTarget,
  input  logic       depthZero,
  input  logic       depthFull,
  input  logic       childBit,
  input  logic       valueBit,
  output strobes_t   ctl,
  output logic       busy,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_USE, S_FIN} state_e;

  state_e state, stateNxt;
  logic   modeUp, modeUpNxt;
  logic   undecided;

  always_comb begin
    undecided = !childBit &&
                ((tblType == GT_AND && valueBit) || (tblType == GT_OR && !valueBit));
  end

  always_comb begin
    ctl       = '0;
    stateNxt  = state;
    modeUpNxt = modeUp;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.load  = 1'b1;
        modeUpNxt = 1'b0;
        stateNxt  = S_WAIT;
      end
      S_WAIT: stateNxt = S_USE;
      S_USE: begin
        stateNxt = S_WAIT;
        if (!atTarget) begin
          ctl.stepWalk = 1'b1;
        end else if (!modeUp) begin
          if (tblType == GT_INPUT) begin
            ctl.valSrc = VS_LIT;
            if (depthZero) begin
              ctl.finish = 1'b1;
              stateNxt   = S_FIN;
            end else begin
              ctl.ascend = 1'b1;
              modeUpNxt  = 1'b1;
            end
          end else if (depthFull) begin
            ctl.fail = 1'b1;
            stateNxt = S_FIN;
          end else begin
            ctl.descend = 1'b1;
          end
        end else if (undecided) begin
          ctl.descend = 1'b1;
          ctl.dirOne  = 1'b1;
          modeUpNxt   = 1'b0;
        end else begin
          ctl.valSrc = (tblType == GT_NOT) ? VS_INV : VS_KEEP;
          if (depthZero) begin
            ctl.finish = 1'b1;
            stateNxt   = S_FIN;
          end else begin
            ctl.ascend = 1'b1;
          end
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      modeUp <= 1'b0;
    end else begin
      state  <= stateNxt;
      modeUp <= modeUpNxt;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

endmodule

// File: rtl/netlist_path_eval.sv
module netlist_path_eval
  import npe_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int MAX_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] rootIdx,
  output logic [IDX_W-1:0] tblAddr,
  input  logic [1:0]       tblType,
  input  logic [IDX_W-1:0] tblPredA,
  input  logic [IDX_W-1:0] tblPredB,
  input  logic             tblLit,
  output logic             done,
  output logic             result,
  output logic             error
);

  strobes_t ctl;
  logic     busy, atTarget, depthZero, depthFull, childBit, valueBit;

  npe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .tblType(tblType),
    .atTarget(atTarget), .depthZero(depthZero), .depthFull(depthFull),
    .childBit(childBit), .valueBit(valueBit),
    .ctl(ctl), .busy(busy), .done(done)
  );

  npe_dpath #(.IDX_W(IDX_W), .MAX_DEPTH(MAX_DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rootIdx(rootIdx),
    .tblType(tblType), .tblPredA(tblPredA), .tblPredB(tblPredB), .tblLit(tblLit),
    .tblAddr(tblAddr), .atTarget(atTarget), .depthZero(depthZero),
    .depthFull(depthFull), .childBit(childBit), .valueBit(valueBit),
    .result(result), .error(error)
  );

endmodule

// File: rtl/netlist_path_eval_chk.sv
module netlist_path_eval_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic [IDX_W-1:0] rootIdx,
  input logic [IDX_W-1:0] tblAddr,
  input logic             done,
  input logic             result,
  input logic             error
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !result);

  // R8
  err_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> done);

  // R11
  root_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (tblAddr == $past(rootIdx)));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$stable(tblAddr)) |=> $stable(tblAddr));

endmodule

bind netlist_path_eval netlist_path_eval_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .rootIdx(rootIdx),
  .tblAddr(tblAddr), .done(done), .result(result), .error(error)
);

// File: tb/netlist_path_eval_tb.sv
module netlist_path_eval_tb;

  localparam int IDX_W = 8;
  localparam int MAXD  = 16;
  localparam int NTBL  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [IDX_W-1:0] rootIdx = '0;
  logic [IDX_W-1:0] tblAddr;
  logic [1:0] tblType;
  logic [IDX_W-1:0] tblPredA, tblPredB;
  logic tblLit, done, result, error;

  int compared = 0;
  int mismatched = 0;

  logic [1:0]       tType [NTBL];
  logic [IDX_W-1:0] tA    [NTBL];
  logic [IDX_W-1:0] tB    [NTBL];
  logic             tLit  [NTBL];
  logic             expVal[NTBL];
  int               expDep[NTBL];
  int               nextIdx = 0;
  int unsigned      seed = 32'h1234_5678;

  always #2 clk = ~clk;

  netlist_path_eval #(.IDX_W(IDX_W), .MAX_DEPTH(MAXD)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .rootIdx(rootIdx), .tblAddr(tblAddr),
    .tblType(tblType), .tblPredA(tblPredA), .tblPredB(tblPredB), .tblLit(tblLit),
    .done(done), .result(result), .error(error)
  );

  // table model: one-cycle registered read
  always @(posedge clk) begin
    tblType  <= tType[tblAddr];
    tblPredA <= tA[tblAddr];
    tblPredB <= tB[tblAddr];
    tblLit   <= tLit[tblAddr];
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic clearTbl();
    for (int i = 0; i < NTBL; i++) begin
      tType[i] = 2'b00; tA[i] = '0; tB[i] = '0; tLit[i] = 1'b0;
    end
    nextIdx = 0;
  endtask

  task automatic addGate(input logic [1:0] t, input int a, input int b, input logic lit,
                         output int idx);
    idx = nextIdx;
    tType[idx] = t; tA[idx] = IDX_W'(a); tB[idx] = IDX_W'(b); tLit[idx] = lit;
    nextIdx++;
  endtask

  // reference evaluation in index order (predecessors always lower)
  task automatic evalAll();
    for (int i = 0; i < nextIdx; i++) begin
      int a = int'(tA[i]);
      int b = int'(tB[i]);
      case (tType[i])
        2'b00: begin expVal[i] = tLit[i]; expDep[i] = 0; end
        2'b01: begin expVal[i] = ~expVal[a]; expDep[i] = expDep[a] + 1; end
        2'b10: begin expVal[i] = expVal[a] & expVal[b];
                     expDep[i] = ((expDep[a] > expDep[b]) ? expDep[a] : expDep[b]) + 1; end
        default: begin expVal[i] = expVal[a] | expVal[b];
                     expDep[i] = ((expDep[a] > expDep[b]) ? expDep[a] : expDep[b]) + 1; end
      endcase
    end
  endtask

  task automatic runEval(input int root, output logic r, output logic e);
    bit seen;
    @(negedge clk);
    start = 1'b1; rootIdx = IDX_W'(root);
    @(negedge clk);
    start = 1'b0;
    check("R11 first address", logic'(tblAddr == IDX_W'(root)), 1'b1);
    seen = 0;
    r = 1'bx; e = 1'bx;
    for (int c = 0; c < 60000; c++) begin
      if (done) begin seen = 1; r = result; e = error; break; end
      @(negedge clk);
    end
    check("R9 done seen", logic'(seen), 1'b1);
    @(negedge clk);
    check("R9 done one cycle", done, 1'b0);
    check("R9 result held", result, r);
  endtask

  task automatic t_reset();
    check("R1 done at reset", done, 1'b0);
    check("R1 result at reset", result, 1'b0);
    check("R1 error at reset", error, 1'b0);
  endtask

  task automatic t_inputRoot();
    int i0, i1;
    logic r, e;
    clearTbl();
    addGate(2'b00, 0, 0, 1'b0, i0);
    addGate(2'b00, 0, 0, 1'b1, i1);
    runEval(i0, r, e); check("R2 input root 0", r, 1'b0); check("R2 no error", e, 1'b0);
    runEval(i1, r, e); check("R2 input root 1", r, 1'b1);
  endtask

  task automatic t_truth();
    int z0, o1, z2, o3, g;
    int pa[4] = '{0, 0, 3, 1};
    int pb[4] = '{2, 1, 0, 3};
    logic r, e;
    clearTbl();
    addGate(2'b00, 0, 0, 1'b0, z0);
    addGate(2'b00, 0, 0, 1'b1, o1);
    addGate(2'b00, 0, 0, 1'b0, z2);
    addGate(2'b00, 0, 0, 1'b1, o3);
    evalAll();
    for (int k = 0; k < 4; k++) begin
      addGate(2'b10, pa[k], pb[k], 1'b0, g);
      evalAll();
      runEval(g, r, e); check("R7 AND truth", r, expVal[g]);
      addGate(2'b11, pa[k], pb[k], 1'b0, g);
      evalAll();
      runEval(g, r, e); check("R7 OR truth", r, expVal[g]);
    end
    addGate(2'b01, z0, z0, 1'b0, g); evalAll();
    runEval(g, r, e); check("R7 NOT of 0", r, 1'b1);
    addGate(2'b01, o1, o1, 1'b0, g); evalAll();
    runEval(g, r, e); check("R7 NOT of 1", r, 1'b0);
  endtask

  task automatic t_depth();
    int g, prev;
    logic r, e;
    clearTbl();
    addGate(2'b00, 0, 0, 1'b1, prev);
    for (int k = 0; k < MAXD + 1; k++) begin
      addGate(2'b01, prev, prev, 1'b0, g);
      prev = g;
    end
    evalAll();
    runEval(MAXD, r, e);
    check("R8 depth at limit value", r, expVal[MAXD]);
    check("R8 depth at limit no error", e, 1'b0);
    runEval(MAXD + 1, r, e);
    check("R8 over limit error", e, 1'b1);
    check("R8 over limit result", r, 1'b0);
  endtask

  task automatic t_shortCircuit();
    int z, o, g, prev, deep;
    logic r, e;
    clearTbl();
    addGate(2'b00, 0, 0, 1'b0, z);
    addGate(2'b00, 0, 0, 1'b1, o);
    prev = o;
    for (int k = 0; k < MAXD + 4; k++) begin
      addGate(2'b01, prev, prev, 1'b0, g);
      prev = g;
    end
    deep = prev;
    // fields reversed: deep subtree in field A, shallow input in field B
    addGate(2'b10, deep, z, 1'b0, g);
    runEval(g, r, e);
    check("R5 AND decided by 0", r, 1'b0);
    check("R4 R5 deep side skipped", e, 1'b0);
    addGate(2'b11, deep, o, 1'b0, g);
    runEval(g, r, e);
    check("R6 OR decided by 1", r, 1'b1);
    check("R4 R6 deep side skipped", e, 1'b0);
    addGate(2'b10, o, deep, 1'b0, g);
    runEval(g, r, e);
    check("R7 undecided AND visits deep side", e, 1'b1);
    addGate(2'b11, deep, z, 1'b0, g);
    runEval(g, r, e);
    check("R7 undecided OR visits deep side", e, 1'b1);
  endtask

  task automatic t_random();
    int g, used;
    logic r, e;
    clearTbl();
    for (int k = 0; k < 8; k++) addGate(2'b00, 0, 0, logic'(rnd() & 1), g);
    for (int k = 8; k < 48; k++) begin
      logic [1:0] t;
      t = 2'(1 + (rnd() % 3));
      addGate(t, int'(rnd() % k), int'(rnd() % k), 1'b0, g);
    end
    evalAll();
    used = 0;
    for (int i = 8; i < nextIdx && used < 14; i++) begin
      if (expDep[i] <= 6 && expDep[i] >= 2) begin
        runEval(i, r, e);
        check("R2 random netlist value", r, expVal[i]);
        check("R2 random netlist no error", e, 1'b0);
        used++;
      end
    end
  endtask

  task automatic t_busyIgnore();
    int g, prev, other;
    int dones;
    logic r;
    clearTbl();
    addGate(2'b00, 0, 0, 1'b1, prev);
    for (int k = 0; k < 10; k++) begin
      addGate(2'b01, prev, prev, 1'b0, g);
      prev = g;
    end
    addGate(2'b00, 0, 0, 1'b0, other);
    @(negedge clk);
    start = 1'b1; rootIdx = IDX_W'(prev);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; rootIdx = IDX_W'(other);
    @(negedge clk);
    start = 1'b0;
    dones = 0; r = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      if (done) begin dones++; r = result; end
      @(negedge clk);
    end
    check("R10 single done", logic'(dones == 1), 1'b1);
    check("R10 first root value kept", r, 1'b1);
    check("R9 result held after idle", result, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < NTBL; i++) begin
      tType[i] = 2'b00; tA[i] = '0; tB[i] = '0; tLit[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_inputRoot();
    t_truth();
    t_depth();
    t_shortCircuit();
    t_random();
    t_busyIgnore();
    summary();
    $finish;
  end

endmodule